// File: doc/BRIEF.md
# ADC Configuration Register Access Engine

This block lets on-chip logic read and change the single 8-bit configuration register of a successive-approximation ADC over a four-wire serial link. Every access is a 16-bit frame with the clock idling low. Data leaves the controller on the falling clock edge and is captured on the rising edge, most significant bit first. The first byte of a frame is a fixed command byte. In a write frame the second byte carries the new register value. In a read frame the second byte is returned by the ADC.

A client issues one of three commands: read, write, or modify. A modify sets or clears one chosen bit while keeping all other bits. It does this with a read frame, a minimum chip-select idle gap, and then a write frame carrying the patched byte, so no other command can run in between. Register access works only when the ADC's serial input is wired to the controller's data output, which is signalled by the strap `link_ok`. When the strap is high, the block writes the default register value once, right after reset. The block also keeps a byte image of the register and a mirror of the span-compression bit.

Top module: `adc_cfg_engine`

The sequencer states are: `SQ_BOOT` (reset default write), `SQ_IDLE` (accepting commands), `SQ_READ` (read frame in flight), `SQ_GAP` (chip-select idle count inside a modify) and `SQ_WRITE` (write frame in flight). Its transitions are:
- BOOT→WRITE when `link_ok` is high, and BOOT→IDLE when it is low.
- IDLE→READ for a read or modify command, and IDLE→WRITE for a write command.
- READ→IDLE at the end of a plain read, and READ→GAP at the end of the read frame of a modify.
- GAP→WRITE once the idle count expires.
- WRITE→IDLE when the write frame ends.

The frame shifter has three phases: `PH_IDLE`, `PH_LOW` (clock low half) and `PH_HIGH` (clock high half).

## Requirements
- R1: A write frame shifts out the command byte 0x14 and then the value, 16 bits MSB first. The clock idles low, MOSI changes only after a falling edge, and each frame has exactly 16 rising edges.
- R2: A read frame shifts out the command byte 0x54 and then 0xFF. `rd_data` receives the 8 bits sampled on the rising edges of the second byte.
- R3: After reset with `link_ok` high, the block writes 0xE1 to the register without being asked. When `HIGHZ_AT_RESET` is 1, it writes 0xE5 instead (bit 2 set).
- R4: Modify (`cmd_op`=2) reads the register, replaces bit `cmd_bit` with `cmd_bitval`, and writes the result. The other seven bits are unchanged.
- R5: Between the read frame and the write frame of a modify, chip select stays high for at least `IDLE_CYCLES` clock cycles.
- R6: A `cmd_valid` seen while `busy` is high raises `cmd_err` on the next cycle, and the command is dropped.
- R7: Opcode 3, or any command while `link_ok` is low, raises `cmd_err` and produces no frame. Opcodes are 0 read, 1 write and 2 modify.
- R8: `span_comp` equals bit 3 of the last value written. It is 0 in reset.
- R9: `busy` is high from the cycle after acceptance until the command ends. `done` is a one-cycle pulse at that end. `rd_data` holds the last byte read or written.
- R10: While chip select is high, the clock is low and MOSI is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_ok | input | 1 | Strap: ADC serial input is wired to controller data out |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 read, 1 write, 2 modify, 3 reserved |
| cmd_wdata | input | 8 | Value for a write |
| cmd_bit | input | 3 | Bit index for a modify |
| cmd_bitval | input | 1 | New bit value for a modify |
| busy | output | 1 | Command or boot write in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | One-cycle rejection pulse |
| rd_data | output | 8 | Register image |
| span_comp | output | 1 | Mirror of bit 3 last written |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to ADC |
| spi_miso | input | 1 | Serial data from ADC |

## Verification
The embedded assertions check several properties on every cycle:
- every frame carries exactly 16 rising clock edges;
- a frame never starts while another is in flight;
- `span_comp` moves only at a frame end;
- `done` never lasts two cycles;
- a command during busy is always answered with `cmd_err`;
- the chip-select gap inside a modify always reaches its minimum.

Only the bench's serial slave model can show that the right bytes travel on the wire: the command codes, a returned byte landing in `rd_data`, a modify preserving the seven untouched bits, the reset default write, and rejected commands leaving the ADC register untouched.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    localparam int FRAME_BITS = 16;
    localparam logic [7:0] CMD_WR      = 8'h14;
    localparam logic [7:0] CMD_RD      = 8'h54;
    localparam logic [7:0] CFG_DEFAULT = 8'hE1;
    localparam logic [7:0] RD_FILL     = 8'hFF;
    localparam int BIT_SPAN  = 3;
    localparam int BIT_HIGHZ = 2;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_MODIFY = 2'd2,
        OP_RSVD   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } ph_e;

    typedef enum logic [2:0] {
        SQ_BOOT  = 3'd0,
        SQ_IDLE  = 3'd1,
        SQ_READ  = 3'd2,
        SQ_GAP   = 3'd3,
        SQ_WRITE = 3'd4
    } sq_e;
endpackage

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
    import cfg_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] tx_word,
    input  logic                  miso,
    output logic                  cs_n,
    output logic                  sclk,
    output logic                  mosi,
    output logic                  done,
    output logic [7:0]            rx_byte
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int BW = $clog2(FRAME_BITS);

    ph_e                   ph, ph_nxt;
    logic [DW-1:0]         div_cnt;
    logic [BW-1:0]         bit_cnt;
    logic [FRAME_BITS-1:0] tx_sr;
    logic [7:0]            rx_sr;
    logic                  div_end, last_bit;

    assign div_end  = (div_cnt == DW'(CLK_DIV - 1));
    assign last_bit = (bit_cnt == BW'(FRAME_BITS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph <= PH_IDLE;
        else        ph <= ph_nxt;
    end

    always_comb begin
        ph_nxt = ph;
        unique case (ph)
            PH_IDLE: if (start)   ph_nxt = PH_LOW;
            PH_LOW:  if (div_end) ph_nxt = PH_HIGH;
            PH_HIGH: if (div_end) ph_nxt = last_bit ? PH_IDLE : PH_LOW;
            default: ph_nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sr   <= '1;
            rx_sr   <= '0;
            rx_byte <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (ph)
                PH_IDLE: if (start) begin
                    tx_sr   <= tx_word;
                    bit_cnt <= '0;
                    div_cnt <= '0;
                end
                PH_LOW: begin
                    if (div_end) begin
                        div_cnt <= '0;
                        rx_sr   <= {rx_sr[6:0], miso};
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (div_end) begin
                        div_cnt <= '0;
                        if (last_bit) begin
                            done    <= 1'b1;
                            rx_byte <= rx_sr;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            tx_sr   <= {tx_sr[FRAME_BITS-2:0], 1'b1};
                        end
                    end else begin
                        div_cnt <= div_cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign cs_n = (ph == PH_IDLE);
    assign sclk = (ph == PH_HIGH);
    assign mosi = (ph == PH_IDLE) ? 1'b1 : tx_sr[FRAME_BITS-1];

    // R1: a frame is only requested when no frame is in flight
    assert_start_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (ph == PH_IDLE));
endmodule

// File: rtl/cfg_sequencer.sv
module cfg_sequencer
    import cfg_pkg::*;
#(
    parameter int IDLE_CYCLES    = 4,
    parameter bit HIGHZ_AT_RESET = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  link_ok,
    input  logic                  cmd_valid,
    input  logic [1:0]            cmd_op,
    input  logic [7:0]            cmd_wdata,
    input  logic [2:0]            cmd_bit,
    input  logic                  cmd_bitval,
    output logic                  fr_start,
    output logic [FRAME_BITS-1:0] fr_tx,
    input  logic                  fr_done,
    input  logic [7:0]            fr_rx,
    output logic                  busy,
    output logic                  done,
    output logic                  cmd_err,
    output logic [7:0]            rd_data,
    output logic                  span_comp,
    output logic                  rmw_second
);
    localparam int GW = (IDLE_CYCLES > 1) ? $clog2(IDLE_CYCLES) : 1;
    localparam logic [7:0] BOOT_VAL = CFG_DEFAULT | (HIGHZ_AT_RESET ? (8'h1 << BIT_HIGHZ) : 8'h0);

    sq_e           state, nxt;
    op_e           op_q;
    logic [2:0]    bit_q;
    logic          val_q;
    logic [7:0]    mod_val;
    logic [GW-1:0] gap_cnt;
    logic          booting;
    logic          accept;
    logic          gap_end;

    function automatic logic [7:0] patch_bit(input logic [7:0] v, input logic [2:0] idx,
                                             input logic bv);
        logic [7:0] r;
        r      = v;
        r[idx] = bv;
        return r;
    endfunction

    assign accept  = link_ok && (op_e'(cmd_op) != OP_RSVD);
    assign gap_end = (gap_cnt == GW'(IDLE_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_BOOT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SQ_BOOT:  nxt = link_ok ? SQ_WRITE : SQ_IDLE;
            SQ_IDLE:  if (cmd_valid && accept)
                          nxt = (op_e'(cmd_op) == OP_WRITE) ? SQ_WRITE : SQ_READ;
            SQ_READ:  if (fr_done) nxt = (op_q == OP_MODIFY) ? SQ_GAP : SQ_IDLE;
            SQ_GAP:   if (gap_end) nxt = SQ_WRITE;
            SQ_WRITE: if (fr_done) nxt = SQ_IDLE;
            default:  nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_start  <= 1'b0;
            fr_tx     <= '1;
            done      <= 1'b0;
            cmd_err   <= 1'b0;
            rd_data   <= '0;
            span_comp <= 1'b0;
            op_q      <= OP_READ;
            bit_q     <= '0;
            val_q     <= 1'b0;
            mod_val   <= '0;
            gap_cnt   <= '0;
            booting   <= 1'b1;
        end else begin
            fr_start <= 1'b0;
            done     <= 1'b0;
            cmd_err  <= cmd_valid && ((state != SQ_IDLE) || !accept);
            unique case (state)
                SQ_BOOT: begin
                    if (link_ok) begin
                        fr_start <= 1'b1;
                        fr_tx    <= {CMD_WR, BOOT_VAL};
                        op_q     <= OP_WRITE;
                    end else begin
                        booting <= 1'b0;
                    end
                end
                SQ_IDLE: begin
                    if (cmd_valid && accept) begin
                        op_q     <= op_e'(cmd_op);
                        bit_q    <= cmd_bit;
                        val_q    <= cmd_bitval;
                        fr_start <= 1'b1;
                        fr_tx    <= (op_e'(cmd_op) == OP_WRITE) ? {CMD_WR, cmd_wdata}
                                                                : {CMD_RD, RD_FILL};
                    end
                end
                SQ_READ: begin
                    if (fr_done) begin
                        rd_data <= fr_rx;
                        if (op_q == OP_MODIFY) begin
                            mod_val <= patch_bit(fr_rx, bit_q, val_q);
                            gap_cnt <= '0;
                        end else begin
                            done <= 1'b1;
                        end
                    end
                end
                SQ_GAP: begin
                    gap_cnt <= gap_cnt + 1'b1;
                    if (gap_end) begin
                        fr_start <= 1'b1;
                        fr_tx    <= {CMD_WR, mod_val};
                    end
                end
                SQ_WRITE: begin
                    if (fr_done) begin
                        rd_data   <= fr_tx[7:0];
                        span_comp <= fr_tx[BIT_SPAN];
                        done      <= !booting;
                        booting   <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy       = (state != SQ_IDLE);
    assign rmw_second = (state == SQ_WRITE) && (op_q == OP_MODIFY);

    // R6: a command presented while busy is answered with an error pulse
    assert_busy_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> cmd_err);

    // R9: completion is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/adc_cfg_engine.sv
module adc_cfg_engine
    import cfg_pkg::*;
#(
    parameter int CLK_DIV        = 2,
    parameter int IDLE_CYCLES    = 4,
    parameter bit HIGHZ_AT_RESET = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       link_ok,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic [7:0] cmd_wdata,
    input  logic [2:0] cmd_bit,
    input  logic       cmd_bitval,
    output logic       busy,
    output logic       done,
    output logic       cmd_err,
    output logic [7:0] rd_data,
    output logic       span_comp,
    output logic       spi_cs_n,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    localparam int HW = $clog2(IDLE_CYCLES + 1);
    localparam int EW = $clog2(FRAME_BITS + 1);

    logic                  fr_start, fr_done, rmw_second;
    logic [FRAME_BITS-1:0] fr_tx;
    logic [7:0]            fr_rx;

    cfg_sequencer #(
        .IDLE_CYCLES   (IDLE_CYCLES),
        .HIGHZ_AT_RESET(HIGHZ_AT_RESET)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_ok   (link_ok),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_wdata (cmd_wdata),
        .cmd_bit   (cmd_bit),
        .cmd_bitval(cmd_bitval),
        .fr_start  (fr_start),
        .fr_tx     (fr_tx),
        .fr_done   (fr_done),
        .fr_rx     (fr_rx),
        .busy      (busy),
        .done      (done),
        .cmd_err   (cmd_err),
        .rd_data   (rd_data),
        .span_comp (span_comp),
        .rmw_second(rmw_second)
    );

    spi_frame_shifter #(
        .CLK_DIV(CLK_DIV)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (fr_start),
        .tx_word(fr_tx),
        .miso   (spi_miso),
        .cs_n   (spi_cs_n),
        .sclk   (spi_sclk),
        .mosi   (spi_mosi),
        .done   (fr_done),
        .rx_byte(fr_rx)
    );

    // checker state: chip-select high run length and rising edges per frame
    logic [HW-1:0] hi_run;
    logic [EW-1:0] edge_cnt;
    logic          sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run   <= '0;
            edge_cnt <= '0;
            sclk_d   <= 1'b0;
        end else begin
            sclk_d <= spi_sclk;
            if (!spi_cs_n)                      hi_run <= '0;
            else if (hi_run != HW'(IDLE_CYCLES)) hi_run <= hi_run + 1'b1;
            if (spi_cs_n)                       edge_cnt <= '0;
            else if (spi_sclk && !sclk_d)       edge_cnt <= edge_cnt + 1'b1;
        end
    end

    // R1: every frame carries exactly FRAME_BITS rising clock edges
    assert_frame_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> (edge_cnt == EW'(FRAME_BITS)));

    // R5: minimum chip-select idle before the write frame of a modify
    assert_rmw_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(spi_cs_n) && rmw_second) |-> (hi_run >= HW'(IDLE_CYCLES)));

    // R8: the span mirror only moves when a frame has just completed
    assert_span_at_frame_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(span_comp) |-> $past(fr_done));
endmodule

// File: tb/tb_adc_cfg_engine.sv
module tb_adc_cfg_engine;
    localparam int IDLE_CYCLES = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       link_ok = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [7:0] cmd_wdata = 8'h00;
    logic [2:0] cmd_bit = 3'd0;
    logic       cmd_bitval = 1'b0;
    logic       busy, done, cmd_err, span_comp;
    logic [7:0] rd_data;
    logic       spi_cs_n, spi_sclk, spi_mosi;
    logic       spi_miso = 1'b0;

    adc_cfg_engine #(.CLK_DIV(2), .IDLE_CYCLES(IDLE_CYCLES), .HIGHZ_AT_RESET(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .link_ok(link_ok), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_bit(cmd_bit), .cmd_bitval(cmd_bitval),
        .busy(busy), .done(done), .cmd_err(cmd_err), .rd_data(rd_data),
        .span_comp(span_comp), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // serial slave model of the ADC register
    int         s_cnt = 0;
    logic [15:0] s_sh = '0;
    logic [7:0] s_reg = 8'h00;
    logic [7:0] s_cmd = 8'h00;
    int n_wr = 0, n_rd = 0, n_bad = 0;
    int hi_run = 0, last_gap = 0, idle_bad = 0;

    always @(negedge spi_cs_n) s_cnt = 0;
    always @(posedge spi_sclk) begin
        s_sh = {s_sh[14:0], spi_mosi};
        s_cnt++;
        if (s_cnt == 8) s_cmd = s_sh[7:0];
    end
    always @(negedge spi_sclk)
        if (s_cnt >= 8 && s_cnt < 16 && s_cmd == 8'h54) spi_miso = s_reg[15 - s_cnt];
    always @(posedge spi_cs_n) begin
        if (s_cnt > 0) begin
            if (s_cnt != 16) n_bad++;
            else if (s_cmd == 8'h14) begin s_reg = s_sh[7:0]; n_wr++; end
            else if (s_cmd == 8'h54) begin n_rd++; if (s_sh[7:0] != 8'hFF) n_bad++; end
            else n_bad++;
            s_cnt = 0;
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (spi_cs_n) begin
                hi_run++;
                if (!spi_mosi || spi_sclk) idle_bad++;
            end else begin
                if (hi_run > 0) last_gap = hi_run;
                hi_run = 0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_patch(input logic [7:0] v, input int idx, input logic b);
        logic [7:0] r;
        r = v;
        r[idx] = b;
        return r;
    endfunction

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy && n < 3000) begin @(negedge clk); n++; end
        chk({req, " completion"}, {31'd0, busy}, 32'd0);
    endtask

    // issue one command; returns error flag seen on the cycle after the strobe
    task automatic do_cmd(input logic [1:0] op, input logic [7:0] d, input logic [2:0] b,
                          input logic v, output logic got_err);
        int n;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_wdata = d; cmd_bit = b; cmd_bitval = v;
        @(negedge clk);
        cmd_valid = 1'b0;
        got_err = cmd_err;
        if (!got_err) begin
            chk("R9 busy after accept", {31'd0, busy}, 32'd1);
            n = 0;
            while (!done && n < 3000) begin @(negedge clk); n++; end
            chk("R9 done seen", {31'd0, done}, 32'd1);
            @(negedge clk);
            chk("R9 done single cycle", {31'd0, done}, 32'd0);
            chk("R9 idle after done", {31'd0, busy}, 32'd0);
        end
    endtask

    initial begin
        while (cycles < 150000) @(negedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic       e;
        logic [7:0] pre, expv;
        int         wr0, rd0;
        void'($urandom(32'd5150));
        repeat (4) @(negedge clk);
        chk("R10 cs idle in reset", {31'd0, spi_cs_n}, 32'd1);
        chk("R10 sclk low in reset", {31'd0, spi_sclk}, 32'd0);
        chk("R8 span reset", {31'd0, span_comp}, 32'd0);
        chk("R9 done reset", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        wait_idle("R3 boot");
        chk("R3 boot value", {24'd0, s_reg}, 32'hE1);
        chk("R3 boot one write", n_wr, 1);
        chk("R9 image after boot", {24'd0, rd_data}, 32'hE1);
        chk("R8 span after boot", {31'd0, span_comp}, 32'd0);

        // directed read
        s_reg = 8'h5A;
        do_cmd(2'd0, 8'h00, 3'd0, 1'b0, e);
        chk("R2 read no error", {31'd0, e}, 32'd0);
        chk("R2 read value", {24'd0, rd_data}, 32'h5A);
        chk("R2 read frame count", n_rd, 1);

        // directed write setting span
        do_cmd(2'd1, 8'h08, 3'd0, 1'b0, e);
        chk("R1 write value", {24'd0, s_reg}, 32'h08);
        chk("R8 span set", {31'd0, span_comp}, 32'd1);

        // modify clearing span bit, others preserved
        s_reg = 8'hFF;
        do_cmd(2'd2, 8'h00, 3'd3, 1'b0, e);
        chk("R4 modify clear bit3", {24'd0, s_reg}, 32'hF7);
        chk("R8 span cleared", {31'd0, span_comp}, 32'd0);
        chk("R5 gap length", {31'd0, (last_gap >= IDLE_CYCLES)}, 32'd1);
        s_reg = 8'h00;
        do_cmd(2'd2, 8'h00, 3'd7, 1'b1, e);
        chk("R4 modify top bit", {24'd0, s_reg}, 32'h80);
        s_reg = 8'hFF;
        do_cmd(2'd2, 8'h00, 3'd0, 1'b0, e);
        chk("R4 modify bottom bit", {24'd0, s_reg}, 32'hFE);

        // random mix
        for (int i = 0; i < 30; i++) begin
            logic [1:0] op;
            logic [7:0] d;
            logic [2:0] b;
            logic       v;
            logic       sp;
            op  = 2'($urandom_range(0, 2));
            d   = 8'($urandom);
            b   = 3'($urandom);
            v   = 1'($urandom);
            pre = 8'($urandom);
            sp  = span_comp;
            s_reg = pre;
            do_cmd(op, d, b, v, e);
            chk("R7 legal op accepted", {31'd0, e}, 32'd0);
            if (op == 2'd0) begin
                chk("R2 random read", {24'd0, rd_data}, {24'd0, pre});
                chk("R8 span kept on read", {31'd0, span_comp}, {31'd0, sp});
            end else if (op == 2'd1) begin
                chk("R1 random write", {24'd0, s_reg}, {24'd0, d});
                chk("R8 random span", {31'd0, span_comp}, {31'd0, d[3]});
            end else begin
                expv = exp_patch(pre, int'(b), v);
                chk("R4 random modify", {24'd0, s_reg}, {24'd0, expv});
                chk("R9 image after modify", {24'd0, rd_data}, {24'd0, expv});
                chk("R5 random gap", {31'd0, (last_gap >= IDLE_CYCLES)}, 32'd1);
            end
        end

        // command while busy is rejected
        s_reg = 8'h21;
        wr0 = n_wr;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0;
        @(negedge clk);
        cmd_op = 2'd1; cmd_wdata = 8'h33;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R6 busy error pulse", {31'd0, cmd_err}, 32'd1);
        wait_idle("R6 read");
        chk("R6 rejected write absent", {24'd0, s_reg}, 32'h21);
        chk("R6 no write frame", n_wr, wr0);
        chk("R6 read still served", {24'd0, rd_data}, 32'h21);

        // reserved opcode
        wr0 = n_wr; rd0 = n_rd;
        do_cmd(2'd3, 8'h44, 3'd1, 1'b1, e);
        chk("R7 reserved op error", {31'd0, e}, 32'd1);
        repeat (80) @(negedge clk);
        chk("R7 reserved no frame", n_wr + n_rd, wr0 + rd0);

        // link not ready
        link_ok = 1'b0;
        do_cmd(2'd1, 8'h66, 3'd0, 1'b0, e);
        chk("R7 link low error", {31'd0, e}, 32'd1);
        repeat (80) @(negedge clk);
        chk("R7 link low register kept", {24'd0, s_reg}, 32'h21);
        link_ok = 1'b1;

        chk("R10 idle lines", idle_bad, 0);
        chk("R1 R2 frame format", n_bad, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule